// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles that a host issues to a byte-wide flash device. Each write arrives as a one-clock strobe with its address and data byte already valid. The block recognises the unlock handshake: a key byte AAh at unlock address A, then 55h at unlock address B, then a command byte at address A. From that handshake it selects one of four outcomes: plain read mode, identification mode, an armed byte program, or an armed erase. An erase needs a second key pair before its final cycle. Any write that breaks the expected order drops the decoder back to read mode.

When a program or erase is fully specified, the block emits a one-clock start pulse to the embedded program/erase engine. The pulse comes with an operation code and the latched target address and data, and these values stay held until the next start. After a start, writes are shut out until the engine raises busy. While a program or chip erase is running, writes stay shut out. In identification mode the block answers reads with a maker code, a device code, or the protect flag of one sector. The memory array, the protect flags' storage and capture of raw strobes from pins are outside the block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_o is 0 (read), op_start is 0, op_code is 0 and id_data is 00h.
- R2: An unlock handshake is AAh written at an address whose low UNLOCK_W bits equal UNLOCK_A (5555h), then 55h at low bits equal to UNLOCK_B (2AAAh), then a command byte at UNLOCK_A. Address bits above UNLOCK_W are ignored. While a handshake or an armed command is incomplete, mode_o is 2.
- R3: A write that does not continue the current handshake returns the decoder to read mode (mode_o 0) and clears identification mode without a start. This includes F0h at any address and the handshake ending in F0h.
- R4: Command byte 90h selects identification mode (mode_o 1). It persists across any number of reads and ends only with the next write that is not part of a new handshake.
- R5: id_data follows rd_addr with one clock of latency. In identification mode, rd_addr[7:0]=00h gives 01h and rd_addr[7:0]=01h gives 20h. rd_addr[1:0]=2'b10 gives prot_flags[rd_addr[16:14]] on bit 0 with bits 7:1 zero. Any other address gives 00h. Outside identification mode id_data is 00h.
- R6: Command byte A0h arms a program. The next accepted write, at any address and with any data including F0h, raises op_start with op_code 1, and op_addr/op_data equal to that write.
- R7: Command byte 80h, then AAh at UNLOCK_A, then 55h at UNLOCK_B, then 10h at UNLOCK_A raises op_start with op_code 2. Any other sixth byte at a non-UNLOCK_A address returns to read mode with no start, unless that byte is 30h.
- R8: The same erase handshake ending in 30h at any address raises op_start with op_code 3, and op_addr equals that address.
- R9: op_start is high for exactly one clock per start, and op_code, op_addr and op_data do not change between starts.
- R10: From a start until eng_busy is seen high, mode_o is 3 and writes are ignored. While eng_busy is high after a program or chip erase, mode_o stays 3 and writes stay ignored. Read mode returns when eng_busy falls.
- R11: While eng_busy is high after a sector erase, writes are decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-clock write cycle strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data byte |
| rd_addr | input | ADDR_W | Read address for identification responses |
| prot_flags | input | 2**SECT_W | Per-sector protect flags |
| eng_busy | input | 1 | Program/erase engine busy |
| mode_o | output | 2 | 0 read, 1 identification, 2 handshake in progress, 3 locked |
| id_data | output | 8 | Identification read response |
| op_start | output | 1 | One-clock operation start pulse |
| op_code | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| op_addr | output | ADDR_W | Latched operation address |
| op_data | output | 8 | Latched operation data |

## Verification
The bench builds the decoder with its defaults: a 17-bit address, eight sectors, a 15-bit unlock compare and a registered identification response. The 15-bit compare leaves bits 16:15 outside the match, so the bench can show that unlock addresses carrying those bits still match. Eight sectors let the three upper address bits pick protect flags across the whole range, sectors 0 and 7 included. The registered response gives a fixed one-clock read latency, and every identification check samples at that latency.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      MODE_READ  = 2'd0,
      MODE_IDENT = 2'd1,
      MODE_SEQ   = 2'd2,
      MODE_LOCK  = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PROG = 2'd1,
      OP_CHIP = 2'd2,
      OP_SECT = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KEY1,
      ST_KEY2,
      ST_PGM_ARM,
      ST_ERS_ARM,
      ST_ERS_KEY1,
      ST_ERS_KEY2
   } seq_e;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_ERASE  = 8'h80;
   localparam logic [7:0] CMD_CHIP   = 8'h10;
   localparam logic [7:0] CMD_SECT   = 8'h30;

endpackage

// File: rtl/flash_unlock_match.sv
module flash_unlock_match #(
   parameter int unsigned CMP_W  = 15,
   parameter int unsigned ADDR_A = 'h5555,
   parameter int unsigned ADDR_B = 'h2AAA
) (
   input  logic [CMP_W-1:0] cmp_addr,
   input  logic [7:0]       wr_data,
   output logic             at_addr_a,
   output logic             key_a_hit,
   output logic             key_b_hit
);
   import flash_cmd_pkg::*;

   localparam logic [CMP_W-1:0] A_VAL = CMP_W'(ADDR_A);
   localparam logic [CMP_W-1:0] B_VAL = CMP_W'(ADDR_B);

   logic at_addr_b;

   always_comb begin
      at_addr_a = (cmp_addr == A_VAL);
      at_addr_b = (cmp_addr == B_VAL);
      key_a_hit = at_addr_a && (wr_data == KEY_FIRST);
      key_b_hit = at_addr_b && (wr_data == KEY_SECOND);
   end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    accept,
   input  logic                    at_addr_a,
   input  logic                    key_a_hit,
   input  logic                    key_b_hit,
   input  logic [7:0]              wr_data,
   output flash_cmd_pkg::seq_e     state_o,
   output logic                    ident_o,
   output logic                    fire_o,
   output flash_cmd_pkg::op_e      fire_code_o
);
   import flash_cmd_pkg::*;

   seq_e st_q, st_d;
   logic id_q, id_d;

   always_comb begin
      st_d        = st_q;
      id_d        = id_q;
      fire_o      = 1'b0;
      fire_code_o = OP_NONE;
      if (accept) begin
         unique case (st_q)
            ST_IDLE: begin
               if (key_a_hit) st_d = ST_KEY1;
               else           id_d = 1'b0;
            end
            ST_KEY1: begin
               if (key_b_hit) begin
                  st_d = ST_KEY2;
               end else begin
                  st_d = ST_IDLE;
                  id_d = 1'b0;
               end
            end
            ST_KEY2: begin
               st_d = ST_IDLE;
               id_d = 1'b0;
               if (at_addr_a) begin
                  case (wr_data)
                     CMD_IDENT: id_d = 1'b1;
                     CMD_PROG:  st_d = ST_PGM_ARM;
                     CMD_ERASE: st_d = ST_ERS_ARM;
                     default:   st_d = ST_IDLE;
                  endcase
               end
            end
            ST_PGM_ARM: begin
               st_d        = ST_IDLE;
               fire_o      = 1'b1;
               fire_code_o = OP_PROG;
            end
            ST_ERS_ARM: begin
               if (key_a_hit) st_d = ST_ERS_KEY1;
               else           st_d = ST_IDLE;
            end
            ST_ERS_KEY1: begin
               if (key_b_hit) st_d = ST_ERS_KEY2;
               else           st_d = ST_IDLE;
            end
            ST_ERS_KEY2: begin
               st_d = ST_IDLE;
               if (at_addr_a && (wr_data == CMD_CHIP)) begin
                  fire_o      = 1'b1;
                  fire_code_o = OP_CHIP;
               end else if (wr_data == CMD_SECT) begin
                  fire_o      = 1'b1;
                  fire_code_o = OP_SECT;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         id_q <= 1'b0;
      end else begin
         st_q <= st_d;
         id_q <= id_d;
      end
   end

   assign state_o = st_q;
   assign ident_o = id_q;

endmodule

// File: rtl/flash_op_latch.sv
module flash_op_latch #(
   parameter int unsigned ADDR_W = 17
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  flash_cmd_pkg::op_e  fire_code,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                eng_busy,
   output logic                op_start,
   output flash_cmd_pkg::op_e  op_code,
   output logic [ADDR_W-1:0]   op_addr,
   output logic [7:0]          op_data,
   output logic                lock
);
   import flash_cmd_pkg::*;

   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_start <= 1'b0;
         op_code  <= OP_NONE;
         op_addr  <= '0;
         op_data  <= '0;
         pend_q   <= 1'b0;
      end else begin
         op_start <= fire;
         if (fire) begin
            op_code <= fire_code;
            op_addr <= wr_addr;
            op_data <= wr_data;
            pend_q  <= 1'b1;
         end else if (eng_busy) begin
            pend_q  <= 1'b0;
         end
      end
   end

   assign lock = pend_q || (eng_busy && (op_code != OP_SECT));

endmodule

// File: rtl/flash_id_resp.sv
module flash_id_resp #(
   parameter int unsigned SEL_W    = 8,
   parameter int unsigned SECT_W   = 3,
   parameter logic [7:0]  MFR_CODE = 8'h01,
   parameter logic [7:0]  DEV_CODE = 8'h20,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ident,
   input  logic [SEL_W-1:0]         sel_low,
   input  logic [SECT_W-1:0]        sect_idx,
   input  logic [(1<<SECT_W)-1:0]   prot_flags,
   output logic [7:0]               id_data
);
   localparam logic [SEL_W-1:0] SEL_MFR = SEL_W'(0);
   localparam logic [SEL_W-1:0] SEL_DEV = SEL_W'(1);

   logic [7:0] resp;

   always_comb begin
      resp = 8'h00;
      if (ident) begin
         if (sel_low == SEL_MFR)           resp = MFR_CODE;
         else if (sel_low == SEL_DEV)      resp = DEV_CODE;
         else if (sel_low[1:0] == 2'b10)   resp = {7'd0, prot_flags[sect_idx]};
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) id_data <= 8'h00;
            else        id_data <= resp;
         end
      end else begin : g_comb
         assign id_data = resp;
      end
   endgenerate

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned SECT_W   = 3,
   parameter int unsigned UNLOCK_W = 15,
   parameter int unsigned UNLOCK_A = 'h5555,
   parameter int unsigned UNLOCK_B = 'h2AAA,
   parameter int unsigned ID_SEL_W = 8,
   parameter logic [7:0]  MFR_CODE = 8'h01,
   parameter logic [7:0]  DEV_CODE = 8'h20,
   parameter bit          REG_ID   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [7:0]               wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [(1<<SECT_W)-1:0]   prot_flags,
   input  logic                     eng_busy,
   output logic [1:0]               mode_o,
   output logic [7:0]               id_data,
   output logic                     op_start,
   output logic [1:0]               op_code,
   output logic [ADDR_W-1:0]        op_addr,
   output logic [7:0]               op_data
);
   import flash_cmd_pkg::*;

   localparam int unsigned SECT_LSB = ADDR_W - SECT_W;

   generate
      if (UNLOCK_W > ADDR_W || UNLOCK_W > 32) begin : g_bad_unlock
         $error("UNLOCK_W must fit in ADDR_W and 32 bits");
      end
      if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
         $error("SECT_W must be between 1 and ADDR_W-1");
      end
      if (ID_SEL_W < 2 || ID_SEL_W > ADDR_W) begin : g_bad_sel
         $error("ID_SEL_W must be between 2 and ADDR_W");
      end
      if (UNLOCK_A == UNLOCK_B) begin : g_bad_keys
         $error("unlock addresses must differ");
      end
   endgenerate

   logic  at_a, key_a, key_b, accept, fire, lock, ident;
   op_e   fire_code, code_q;
   seq_e  state;
   mode_e mode;

   flash_unlock_match #(
      .CMP_W  (UNLOCK_W),
      .ADDR_A (UNLOCK_A),
      .ADDR_B (UNLOCK_B)
   ) u_match (
      .cmp_addr  (wr_addr[UNLOCK_W-1:0]),
      .wr_data   (wr_data),
      .at_addr_a (at_a),
      .key_a_hit (key_a),
      .key_b_hit (key_b)
   );

   assign accept = wr_stb && !lock;

   flash_cmd_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .at_addr_a   (at_a),
      .key_a_hit   (key_a),
      .key_b_hit   (key_b),
      .wr_data     (wr_data),
      .state_o     (state),
      .ident_o     (ident),
      .fire_o      (fire),
      .fire_code_o (fire_code)
   );

   flash_op_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .fire_code (fire_code),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .eng_busy  (eng_busy),
      .op_start  (op_start),
      .op_code   (code_q),
      .op_addr   (op_addr),
      .op_data   (op_data),
      .lock      (lock)
   );

   flash_id_resp #(
      .SEL_W    (ID_SEL_W),
      .SECT_W   (SECT_W),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE),
      .REG_OUT  (REG_ID)
   ) u_id (
      .clk        (clk),
      .rst_n      (rst_n),
      .ident      (ident),
      .sel_low    (rd_addr[ID_SEL_W-1:0]),
      .sect_idx   (rd_addr[ADDR_W-1:SECT_LSB]),
      .prot_flags (prot_flags),
      .id_data    (id_data)
   );

   always_comb begin
      if (lock)                  mode = MODE_LOCK;
      else if (state != ST_IDLE) mode = MODE_SEQ;
      else if (ident)            mode = MODE_IDENT;
      else                       mode = MODE_READ;
   end

   assign mode_o  = mode;
   assign op_code = code_q;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int unsigned ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_o,
   input logic [7:0]        id_data,
   input logic              op_start,
   input logic [1:0]        op_code,
   input logic [ADDR_W-1:0] op_addr,
   input logic [7:0]        op_data
);
   import flash_cmd_pkg::*;

   a_r9_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> !op_start);

   a_r9_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
      !op_start |-> ($stable(op_addr) && $stable(op_data) && $stable(op_code)));

   a_r6_code_defined: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> (op_code != OP_NONE));

   a_r10_start_locks: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> (mode_o == MODE_LOCK));

   a_r10_no_start_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_LOCK) |=> !op_start);

   a_r5_id_quiet_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == MODE_READ) && ($past(mode_o) == MODE_READ)) |-> (id_data == 8'h00));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_o   (mode_o),
   .id_data  (id_data),
   .op_start (op_start),
   .op_code  (op_code),
   .op_addr  (op_addr),
   .op_data  (op_data)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [16:0] rd_addr = '0;
   logic [7:0]  prot_flags = 8'h00;
   logic        eng_busy = 1'b0;
   logic [1:0]  mode_o;
   logic [7:0]  id_data;
   logic        op_start;
   logic [1:0]  op_code;
   logic [16:0] op_addr;
   logic [7:0]  op_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   flash_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .prot_flags(prot_flags),
      .eng_busy(eng_busy), .mode_o(mode_o), .id_data(id_data),
      .op_start(op_start), .op_code(op_code), .op_addr(op_addr),
      .op_data(op_data)
   );

   // {address, data, expected mode after the write}
   localparam logic [26:0] VEC [0:23] = '{
      {17'h05555, 8'hAA, 2'd2}, {17'h02AAA, 8'h55, 2'd2}, {17'h05555, 8'h90, 2'd1},
      {17'h00123, 8'h00, 2'd0}, {17'h15555, 8'hAA, 2'd2}, {17'h0AAAA, 8'h55, 2'd2},
      {17'h05555, 8'h90, 2'd1}, {17'h05555, 8'hAA, 2'd2}, {17'h02AAB, 8'h55, 2'd0},
      {17'h05555, 8'hAA, 2'd2}, {17'h02AAA, 8'h55, 2'd2}, {17'h05555, 8'hF0, 2'd0},
      {17'h05555, 8'hAA, 2'd2}, {17'h02AAA, 8'h56, 2'd0}, {17'h05555, 8'hAA, 2'd2},
      {17'h02AAA, 8'h55, 2'd2}, {17'h05555, 8'h80, 2'd2}, {17'h05555, 8'hAA, 2'd2},
      {17'h02AAA, 8'h55, 2'd2}, {17'h05555, 8'h20, 2'd0}, {17'h0D555, 8'hAA, 2'd2},
      {17'h02AAA, 8'h55, 2'd2}, {17'h05555, 8'h90, 2'd1}, {17'h00000, 8'hF0, 2'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic id_rd(input logic [16:0] a, input logic [7:0] exp, input string req);
      rd_addr = a;
      @(negedge clk);
      check(req, id_data, exp);
   endtask

   task automatic erase_pre();
      do_wr(17'h05555, 8'hAA);
      do_wr(17'h02AAA, 8'h55);
      do_wr(17'h05555, 8'h80);
      do_wr(17'h05555, 8'hAA);
      do_wr(17'h02AAA, 8'h55);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mode", mode_o, 2'd0);
      check("R1 start", op_start, 1'b0);
      check("R1 code", op_code, 2'd0);
      check("R1 id", id_data, 8'h00);

      // R2/R3/R4 handshake table
      for (int i = 0; i < 24; i++) begin
         do_wr(VEC[i][26:10], VEC[i][9:2]);
         check($sformatf("R2/R3/R4 vec%0d mode", i), mode_o, VEC[i][1:0]);
         check($sformatf("R3 vec%0d start", i), op_start, 1'b0);
      end

      // R5 identification responses
      prot_flags = 8'h24;
      id_rd(17'h10300, 8'h00, "R5 read mode id quiet");
      do_wr(17'h05555, 8'hAA);
      do_wr(17'h02AAA, 8'h55);
      do_wr(17'h05555, 8'h90);
      id_rd(17'h10300, 8'h01, "R5 maker code");
      id_rd(17'h00401, 8'h20, "R5 device code");
      id_rd(17'h14002, 8'h01, "R5 sector5 protected");
      id_rd(17'h0C002, 8'h00, "R5 sector3 open");
      id_rd(17'h08006, 8'h01, "R5 sector2 protected");
      id_rd(17'h1C002, 8'h00, "R5 sector7 open");
      id_rd(17'h00003, 8'h00, "R5 other address");
      check("R4 ident persists", mode_o, 2'd1);
      do_wr(17'h1FFFF, 8'hF0);
      check("R3 F0 reset", mode_o, 2'd0);
      id_rd(17'h10300, 8'h00, "R5 quiet after exit");

      // R6 program with data F0
      do_wr(17'h05555, 8'hAA);
      do_wr(17'h02AAA, 8'h55);
      do_wr(17'h05555, 8'hA0);
      check("R6 armed mode", mode_o, 2'd2);
      do_wr(17'h13456, 8'hF0);
      check("R6 start", op_start, 1'b1);
      check("R6 code", op_code, 2'd1);
      check("R6 addr", op_addr, 17'h13456);
      check("R6 data", op_data, 8'hF0);
      @(negedge clk);
      check("R9 pulse ends", op_start, 1'b0);
      check("R10 pending lock", mode_o, 2'd3);
      do_wr(17'h05555, 8'hAA);
      check("R10 ignored while pending", mode_o, 2'd3);
      eng_busy = 1'b1;
      @(negedge clk);
      do_wr(17'h05555, 8'hAA);
      do_wr(17'h02AAA, 8'h55);
      check("R10 busy lock", mode_o, 2'd3);
      check("R9 addr held", op_addr, 17'h13456);
      eng_busy = 1'b0;
      @(negedge clk);
      check("R10 released", mode_o, 2'd0);

      // R7 chip erase
      erase_pre();
      do_wr(17'h15555, 8'h10);
      check("R7 start", op_start, 1'b1);
      check("R7 code", op_code, 2'd2);
      eng_busy = 1'b1;
      @(negedge clk);
      do_wr(17'h05555, 8'hAA);
      check("R10 chip busy ignores", mode_o, 2'd3);
      eng_busy = 1'b0;
      @(negedge clk);
      check("R10 chip released", mode_o, 2'd0);

      // R7 chip-erase byte at wrong address
      erase_pre();
      do_wr(17'h02AAA, 8'h10);
      check("R7 wrong addr mode", mode_o, 2'd0);
      check("R7 wrong addr no start", op_start, 1'b0);
      check("R9 fields kept", op_code, 2'd2);

      // R8 sector erase
      erase_pre();
      do_wr(17'h1C7FF, 8'h30);
      check("R8 start", op_start, 1'b1);
      check("R8 code", op_code, 2'd3);
      check("R8 addr", op_addr, 17'h1C7FF);
      eng_busy = 1'b1;
      @(negedge clk);
      @(negedge clk);
      do_wr(17'h05555, 8'hAA);
      check("R11 decoded during sector busy", mode_o, 2'd2);
      do_wr(17'h00000, 8'hF0);
      check("R11 reset during sector busy", mode_o, 2'd0);
      eng_busy = 1'b0;
      @(negedge clk);
      check("R9 addr after sector", op_addr, 17'h1C7FF);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule